// File: doc/BRIEF.md
# Four-Channel DMA Priority Arbiter

This block chooses which of four DMA channels may run a transfer. Each channel raises a request line. The arbiter grants exactly one requester and keeps that grant until the channel pulses transfer-done. It arbitrates again only in the cycle after that pulse.

A two-bit mode code sets the policy. Three codes select fixed priority permutations. The fourth selects a rotating scheme, in which the channel just served drops to lowest priority.

A sticky address-error flag acts as a global stop. Any reported address error sets the flag. This withdraws the active grant, blocks new grants and raises an interrupt. Software can clear the flag only by reading it as 1 and then writing 0. A new error arriving between that read and the write cancels the pending clear.

Top module: `dma_prio_arb`

## Requirements
- R1: After reset `grantOut` is 0, `errIrq` is 0, and the control register reads 0: mode 00, flag clear.
- R2: With mode code 00 (register bits [1:0]), the priority among simultaneous requesters is CH0 > CH1 > CH2 > CH3.
- R3: With mode code 01, the priority is CH0 > CH2 > CH3 > CH1.
- R4: With mode code 10, the priority is CH2 > CH0 > CH1 > CH3.
- R5: With mode code 11, arbitration rotates. CH0 is highest after reset. When a transfer completes in this mode, the channel after the one just served (index plus one, modulo 4) becomes highest.
- R6: When the block is idle and error-free, a single requesting channel is granted at the next clock edge, whatever the mode.
- R7: `grantOut` is one-hot or zero. A grant stays unchanged until `doneIn` is seen while it is active. It clears at that edge, and a new grant can appear no earlier than the following edge.
- R8: When `addrErrIn` is high at a clock edge, the flag (register bit 7) sets, `grantOut` goes to 0, and `errIrq` rises at that edge. No grant is issued while the flag is set.
- R9: Writing 1 to bit 7 never sets the flag. Writing 0 to bit 7 does not clear the flag unless the flag was read as 1 beforehand.
- R10: A read (`regRdEn`) that returns the flag as 1, followed by a write with bit 7 = 0, clears the flag. `errIrq` drops at the edge of that write.
- R11: If `addrErrIn` occurs after the arming read and before the clearing write, that write leaves the flag set.
- R12: Register bits other than [1:0] and 7 always read as 0. `regRdData` shows the register contents combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqIn | input | 4 | Per-channel transfer request |
| doneIn | input | 1 | End-of-transfer strobe for the granted channel |
| addrErrIn | input | 1 | Address-error event pulse |
| regWrEn | input | 1 | Control register write strobe |
| regWrData | input | 16 | Write data: [1:0] mode, [7] flag (write 0 to clear) |
| regRdEn | input | 1 | Read strobe; arms the clear when the flag reads 1 |
| regRdData | output | 16 | Current register contents |
| grantOut | output | 4 | One-hot grant |
| errIrq | output | 1 | Address-error interrupt, follows the flag |

## Verification
The assertions assume `doneIn` pulses only while a grant is active. They also assume `addrErrIn` is a single-cycle event, and that the lone-requester property is judged only in cycles with no address error. The directed stimulus follows these rules. Requests and strobes change on the falling edge. `doneIn` is raised only after a grant has been observed. Error pulses last one cycle and are kept apart from register writes, except in the cases that deliberately place an error between the read and the write.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  localparam int NUM_CH   = 4;
  localparam int CH_W     = $clog2(NUM_CH);
  localparam int REG_W    = 16;
  localparam int MODE_LSB = 0;
  localparam int MODE_W   = 2;
  localparam int FLAG_BIT = 7;

  typedef enum logic [MODE_W-1:0] {
    MODE_ASCEND    = 2'b00,
    MODE_SKIP_ONE  = 2'b01,
    MODE_TWO_FIRST = 2'b10,
    MODE_ROTATE    = 2'b11
  } arbMode_e;

  typedef struct packed {
    logic loadGrant;
    logic releaseGrant;
    logic abortGrant;
  } arbStrobe_t;

  // Channel that holds priority position 'rank' (0 = highest).
  function automatic logic [CH_W-1:0] chanAtRank(arbMode_e mode,
                                                 logic [CH_W-1:0] head,
                                                 logic [CH_W-1:0] rank);
    logic [CH_W-1:0] chan;
    unique case (mode)
      MODE_ASCEND:   chan = rank;
      MODE_SKIP_ONE: begin
        unique case (rank)
          2'd0: chan = 2'd0;
          2'd1: chan = 2'd2;
          2'd2: chan = 2'd3;
          default: chan = 2'd1;
        endcase
      end
      MODE_TWO_FIRST: begin
        unique case (rank)
          2'd0: chan = 2'd2;
          2'd1: chan = 2'd0;
          2'd2: chan = 2'd1;
          default: chan = 2'd3;
        endcase
      end
      default: chan = head + rank;
    endcase
    return chan;
  endfunction
endpackage

// File: rtl/dma_arb_dpath.sv
module dma_arb_dpath
  import dma_arb_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] reqIn,
  input  logic              addrErrIn,
  input  logic              errFlag,
  input  arbMode_e          mode,
  input  arbStrobe_t        strobe,
  output logic [NUM_CH-1:0] grantOut,
  output logic              grantActive,
  output logic              anyReq
);
  logic [CH_W-1:0]   rankChan [NUM_CH];
  logic [NUM_CH-1:0] rankHit;
  logic [CH_W-1:0]   pickIdx;
  logic [CH_W-1:0]   grantIdx;
  logic [CH_W-1:0]   rrHead;
  logic [NUM_CH-1:0] grantReg;

  for (genvar r = 0; r < NUM_CH; r++) begin : g_rank
    assign rankChan[r] = chanAtRank(mode, rrHead, CH_W'(r));
    assign rankHit[r]  = reqIn[rankChan[r]];
  end

  // Lowest requesting rank wins: scan from the bottom, last hit overrides.
  always_comb begin
    pickIdx = '0;
    for (int r = NUM_CH - 1; r >= 0; r--) begin
      if (rankHit[r]) pickIdx = rankChan[r];
    end
  end

  assign anyReq = |reqIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      grantReg <= '0;
      grantIdx <= '0;
    end else if (strobe.abortGrant || strobe.releaseGrant) begin
      grantReg <= '0;
    end else if (strobe.loadGrant) begin
      grantReg <= NUM_CH'(1) << pickIdx;
      grantIdx <= pickIdx;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rrHead <= '0;
    end else if (strobe.releaseGrant && mode == MODE_ROTATE) begin
      rrHead <= grantIdx + CH_W'(1);
    end
  end

  assign grantOut    = grantReg;
  assign grantActive = |grantReg;

  p_grant_onehot_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grantOut));

  p_grant_held_r7: assert property (@(posedge clk) disable iff (!rstN)
    (grantActive && !strobe.releaseGrant && !strobe.abortGrant) |=> $stable(grantOut));

  p_lone_granted_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!grantActive && !errFlag && !addrErrIn && $onehot(reqIn)) |=> (grantOut == $past(reqIn)));

  p_no_grant_in_error_r8: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !grantActive) |=> !grantActive);
endmodule

// File: rtl/dma_arb_ctrl.sv
module dma_arb_ctrl
  import dma_arb_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [REG_W-1:0] regWrData,
  input  logic             regRdEn,
  output logic [REG_W-1:0] regRdData,
  input  logic             addrErrIn,
  input  logic             doneIn,
  input  logic             anyReq,
  input  logic             grantActive,
  output arbMode_e         mode,
  output logic             errFlag,
  output arbStrobe_t       strobe,
  output logic             errIrq
);
  logic clearArmed;
  logic clearNow;

  assign clearNow = regWrEn && !regWrData[FLAG_BIT] && clearArmed && errFlag;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode <= MODE_ASCEND;
    end else if (regWrEn) begin
      mode <= arbMode_e'(regWrData[MODE_LSB +: MODE_W]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errFlag <= 1'b0;
    end else if (addrErrIn) begin
      errFlag <= 1'b1;
    end else if (clearNow) begin
      errFlag <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clearArmed <= 1'b0;
    end else if (addrErrIn || clearNow) begin
      clearArmed <= 1'b0;
    end else if (regRdEn && errFlag) begin
      clearArmed <= 1'b1;
    end
  end

  always_comb begin
    regRdData = '0;
    regRdData[MODE_LSB +: MODE_W] = mode;
    regRdData[FLAG_BIT] = errFlag;
  end

  always_comb begin
    strobe.abortGrant   = addrErrIn;
    strobe.releaseGrant = grantActive && doneIn && !addrErrIn;
    strobe.loadGrant    = !grantActive && !errFlag && !addrErrIn && anyReq;
  end

  assign errIrq = errFlag;

  p_write_cannot_set_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!errFlag && !addrErrIn) |=> !errFlag);

  p_error_sets_flag_r8: assert property (@(posedge clk) disable iff (!rstN)
    addrErrIn |=> (errFlag && errIrq));

  p_unread_write_keeps_r9: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !clearArmed) |=> errFlag);

  p_armed_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && clearArmed && regWrEn && !regWrData[FLAG_BIT] && !addrErrIn) |=> !errIrq);

  p_error_disarms_r11: assert property (@(posedge clk) disable iff (!rstN)
    addrErrIn |=> !clearArmed);
endmodule

// File: rtl/dma_prio_arb.sv
module dma_prio_arb
  import dma_arb_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] reqIn,
  input  logic              doneIn,
  input  logic              addrErrIn,
  input  logic              regWrEn,
  input  logic [REG_W-1:0]  regWrData,
  input  logic              regRdEn,
  output logic [REG_W-1:0]  regRdData,
  output logic [NUM_CH-1:0] grantOut,
  output logic              errIrq
);
  arbMode_e   mode;
  arbStrobe_t strobe;
  logic       errFlag;
  logic       grantActive;
  logic       anyReq;

  dma_arb_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdEn(regRdEn), .regRdData(regRdData),
    .addrErrIn(addrErrIn), .doneIn(doneIn),
    .anyReq(anyReq), .grantActive(grantActive),
    .mode(mode), .errFlag(errFlag), .strobe(strobe), .errIrq(errIrq)
  );

  dma_arb_dpath u_dpath (
    .clk(clk), .rstN(rstN),
    .reqIn(reqIn), .addrErrIn(addrErrIn), .errFlag(errFlag),
    .mode(mode), .strobe(strobe),
    .grantOut(grantOut), .grantActive(grantActive), .anyReq(anyReq)
  );

  p_error_drops_grant_r8: assert property (@(posedge clk) disable iff (!rstN)
    addrErrIn |=> (grantOut == '0));

  p_irq_blocks_grant_r8: assert property (@(posedge clk) disable iff (!rstN)
    (errIrq && grantOut == '0) |=> (grantOut == '0));
endmodule

// File: tb/dma_prio_arb_test.sv
`timescale 1ns/1ps
module dma_prio_arb_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  reqIn = '0;
  logic        doneIn = 1'b0;
  logic        addrErrIn = 1'b0;
  logic        regWrEn = 1'b0;
  logic [15:0] regWrData = '0;
  logic        regRdEn = 1'b0;
  logic [15:0] regRdData;
  logic [3:0]  grantOut;
  logic        errIrq;

  int checkCnt = 0;
  int failCnt  = 0;

  always #2.5 clk = ~clk;

  dma_prio_arb uut (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .doneIn(doneIn),
    .addrErrIn(addrErrIn), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdEn(regRdEn), .regRdData(regRdData), .grantOut(grantOut), .errIrq(errIrq)
  );

  task automatic check(input bit ok, input string tag, input int actual, input int expected);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, actual, expected);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic regWrite(input logic [15:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regWrData = d;
    tick();
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(output logic [15:0] d);
    @(negedge clk);
    regRdEn = 1'b1;
    #0.5 d = regRdData;
    tick();
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic pulseErr();
    @(negedge clk);
    addrErrIn = 1'b1;
    tick();
    @(negedge clk);
    addrErrIn = 1'b0;
  endtask

  // Present 'req', expect 'exp' granted, then finish the transfer.
  task automatic grantCase(input logic [3:0] req, input logic [3:0] exp, input string tag);
    @(negedge clk);
    reqIn = req;
    tick();
    check(grantOut == exp, tag, grantOut, exp);
    @(negedge clk);
    reqIn = '0; doneIn = 1'b1;
    tick();
    check(grantOut == 4'b0, {tag, " release"}, grantOut, 0);
    @(negedge clk);
    doneIn = 1'b0;
  endtask

  task automatic testReset();
    check(grantOut == 4'b0, "R1 grant", grantOut, 0);
    check(errIrq == 1'b0, "R1 irq", errIrq, 0);
    check(regRdData == 16'h0000, "R1 reg", regRdData, 0);
  endtask

  task automatic testFixedOrders();
    regWrite(16'h0000);
    grantCase(4'b1111, 4'b0001, "R2 all");
    grantCase(4'b1110, 4'b0010, "R2 1-3");
    grantCase(4'b1100, 4'b0100, "R2 2-3");
    regWrite(16'h0001);
    grantCase(4'b1010, 4'b1000, "R3 1,3");
    grantCase(4'b0110, 4'b0100, "R3 1,2");
    grantCase(4'b1111, 4'b0001, "R3 all");
    regWrite(16'h0002);
    grantCase(4'b1111, 4'b0100, "R4 all");
    grantCase(4'b0011, 4'b0001, "R4 0,1");
    grantCase(4'b1010, 4'b0010, "R4 1,3");
  endtask

  task automatic testLone();
    for (int m = 0; m < 4; m++) begin
      regWrite(16'(m));
      grantCase(4'b1000, 4'b1000, "R6 lone ch3");
    end
    regWrite(16'h0000);
  endtask

  task automatic testRotate();
    regWrite(16'h0003);
    grantCase(4'b1111, 4'b0001, "R5 head0");
    grantCase(4'b1111, 4'b0010, "R5 head1");
    grantCase(4'b1001, 4'b1000, "R5 head2");
    grantCase(4'b1001, 4'b0001, "R5 head0 wrap");
    regWrite(16'h0000);
  endtask

  task automatic testHold();
    @(negedge clk);
    reqIn = 4'b0011;
    tick();
    check(grantOut == 4'b0001, "R7 first", grantOut, 1);
    @(negedge clk);
    reqIn = 4'b1111;
    tick(); tick(); tick();
    check(grantOut == 4'b0001, "R7 held", grantOut, 1);
    @(negedge clk);
    doneIn = 1'b1;
    tick();
    check(grantOut == 4'b0000, "R7 released", grantOut, 0);
    @(negedge clk);
    doneIn = 1'b0;
    tick();
    check(grantOut == 4'b0001, "R7 rearbitrate", grantOut, 1);
    @(negedge clk);
    reqIn = '0; doneIn = 1'b1;
    tick();
    @(negedge clk);
    doneIn = 1'b0;
  endtask

  task automatic testErrorAndClear();
    logic [15:0] rd;
    regWrite(16'h0080);
    check(errIrq == 1'b0, "R9 write1 no set", errIrq, 0);
    check(regRdData[7] == 1'b0, "R9 flag not set", regRdData[7], 0);
    @(negedge clk);
    reqIn = 4'b0100;
    tick();
    check(grantOut == 4'b0100, "R8 pre-grant", grantOut, 4);
    pulseErr();
    check(grantOut == 4'b0, "R8 grant dropped", grantOut, 0);
    check(errIrq == 1'b1, "R8 irq", errIrq, 1);
    tick(); tick();
    check(grantOut == 4'b0, "R8 blocked", grantOut, 0);
    regWrite(16'h0000);
    check(errIrq == 1'b1, "R9 unread write", errIrq, 1);
    regWrite(16'h0003);
    regRead(rd);
    check(rd == 16'h0083, "R12 layout", rd, 16'h0083);
    regRead(rd);
    pulseErr();
    regWrite(16'h0000);
    check(errIrq == 1'b1, "R11 rearm cancelled", errIrq, 1);
    regRead(rd);
    check(rd[7] == 1'b1, "R10 read flag", rd[7], 1);
    @(negedge clk);
    regWrEn = 1'b1; regWrData = 16'h0000;
    tick();
    check(errIrq == 1'b0, "R10 cleared", errIrq, 0);
    @(negedge clk);
    regWrEn = 1'b0;
    tick();
    check(grantOut == 4'b0100, "R8 resumes", grantOut, 4);
    @(negedge clk);
    reqIn = '0; doneIn = 1'b1;
    tick();
    @(negedge clk);
    doneIn = 1'b0;
    check(regRdData == 16'h0000, "R12 reserved zero", regRdData, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checkCnt, failCnt);
    $finish;
  end

  initial begin
    #12 rstN = 1'b1;
    #1;
    testReset();
    testFixedOrders();
    testLone();
    testHold();
    testRotate();
    testErrorAndClear();
    tick();
    $display("TB_RESULT checks=%0d failures=%0d", checkCnt, failCnt);
    $finish;
  end
endmodule